// File: doc/BRIEF.md
# NTSC Interlaced BT.656 Byte Stream Formatter

This block produces an 8-bit interlaced ITU-R BT.656 byte stream for 525-line, 60 Hz video at one byte per clock. Free-running line and sample counters walk through each line as a 4-byte end-of-active-video (EAV) code, a horizontal blanking fill, a 4-byte start-of-active-video (SAV) code and the active samples in Cb, Y, Cr, Y order. Outside vertical blanking the active samples come from an upstream 4:2:2 source. The block pulls one byte per clock from that source while `sampleTake` is high. During vertical blanking it writes black samples in their place.

Each timing code carries a field bit, a vertical blanking bit and a horizontal bit, plus four protection bits. A static mode input picks one of two places where vertical blanking ends. A static clamp input can force luma below the black level up to the black code. Active data is always kept clear of the two reserved code values. Separate horizontal-drive, vertical-drive and field outputs run in step with the byte stream. Mode and clamp are configuration inputs and are meant to change only while reset is held.

With default parameters a line is 1716 clocks: 4 EAV, 268 blanking, 4 SAV and 1440 active bytes. Line numbers run from 1 to 525.

Top module: `bt656_ntsc_formatter`

## Requirements
- R1: Each line starts at position 0 with the code bytes 0xFF, 0x00, 0x00 and then the XY byte (EAV). The same three bytes and an XY byte sit at positions BLANK_BYTES+4 to BLANK_BYTES+7 (SAV). A line is BLANK_BYTES+ACTIVE_BYTES+8 bytes long, and line 525 is followed by line 1.
- R2: The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, most significant bit first. H is 1 in EAV and 0 in SAV.
- R3: F is 1 on lines 265 through 525 and on lines 1 and 2. F is 0 on lines 3 through 264. `fieldOut` equals F for the byte being output.
- R4: With `blankMode`=0, V is 1 on lines 1–8, 263–271 and 525, and 0 on all other lines. `vdOut` equals V.
- R5: With `blankMode`=1, V is 1 on lines 1–18, 263–281 and 525, and 0 on all other lines. `vdOut` equals V.
- R6: In blanking, the sample bytes alternate 0x80 (chroma, even position) and 0x10 (luma, odd position). This covers the horizontal blanking bytes and the active bytes of lines where V=1.
- R7: On lines with V=0 the active bytes carry the upstream samples in the order Cb, Y, Cr, Y. Luma sits at odd positions. `sampleTake` is high exactly for these positions, and the byte taken in a cycle appears on `byteOut` one clock later.
- R8: With `clampEn`=1, a luma sample below 0x10 is output as 0x10. With `clampEn`=0 such a sample passes unchanged, apart from the limiting in R9.
- R9: An active sample of 0x00 is output as 0x01, and one of 0xFF as 0x FE. This applies to luma and chroma alike.
- R10: `hdOut` is 1 for the EAV and the horizontal blanking bytes (positions 0 to BLANK_BYTES+3), and 0 elsewhere.
- R11: While reset is held, `byteOut` is 0x10 and `hdOut`, `vdOut` and `fieldOut` are 0. The first byte after reset is released is the first EAV byte of line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blankMode | input | 1 | 0: vertical blanking ends at lines 9/272; 1: at lines 19/282 |
| clampEn | input | 1 | 1 forces luma below black up to 0x10 |
| pixIn | input | 8 | Upstream sample, consumed at the clock edge ending a cycle with sampleTake high |
| sampleTake | output | 1 | High when pixIn is consumed this cycle |
| byteOut | output | 8 | Registered BT.656 byte stream |
| hdOut | output | 1 | Horizontal drive, aligned to byteOut |
| vdOut | output | 1 | Vertical drive (V bit), aligned to byteOut |
| fieldOut | output | 1 | Field (F bit), aligned to byteOut |

## Verification
A counter that slips by one sample shows up at once. Within a clock the 0xFF preamble lands in the wrong place, or `hdOut` and `sampleTake` change early. A wrong line count surfaces in the first timing code after the slip, through the F and V bits, and on `vdOut` and `fieldOut` at the same clock. The bench uses short lines, so whole frames run in each blanking mode. It drives data that includes 0x00, 0xFF and sub-black values, so the clamp and limiter corners are reached on luma and chroma positions.

// File: rtl/bt656_fmt_pkg.sv
package bt656_fmt_pkg;
  localparam int FRAME_LINES = 525;
  localparam int LINE_W      = 10;
  localparam logic [7:0] BLACK_Y = 8'h10;
  localparam logic [7:0] ZERO_C  = 8'h80;

  typedef struct packed {
    logic       isCode;    // one of the four timing-code bytes
    logic [1:0] codeIdx;   // byte index inside the code
    logic       hFlag;     // 1 for EAV, 0 for SAV
    logic       fFlag;
    logic       vFlag;
    logic       isLuma;    // odd position
    logic       takePix;   // active byte on a non-blanked line
    logic       hdLvl;
  } fmtStrobe_t;
endpackage

// File: rtl/bt656_fmt_ctrl.sv
module bt656_fmt_ctrl
  import bt656_fmt_pkg::*;
#(
  parameter int BLANK_BYTES  = 268,  // multiple of 2
  parameter int ACTIVE_BYTES = 1440  // multiple of 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blankMode,
  output fmtStrobe_t strb
);
  localparam int LINE_CLKS = BLANK_BYTES + ACTIVE_BYTES + 8;
  localparam int POS_W     = $clog2(LINE_CLKS);
  localparam logic [POS_W-1:0] SAV_AT   = POS_W'(BLANK_BYTES + 4);
  localparam logic [POS_W-1:0] ACT_AT   = POS_W'(BLANK_BYTES + 8);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_CLKS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(FRAME_LINES);

  logic [POS_W-1:0]  pos;
  logic [LINE_W-1:0] line;
  logic              vShort, vLong;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      line <= LINE_W'(1);
    end else if (pos == POS_LAST) begin
      pos  <= '0;
      line <= (line == LINE_LAST) ? LINE_W'(1) : line + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  always_comb begin
    vShort = (line <= 10'd8)  || (line >= 10'd263 && line <= 10'd271) || (line == LINE_LAST);
    vLong  = (line <= 10'd18) || (line >= 10'd263 && line <= 10'd281) || (line == LINE_LAST);
    strb.vFlag   = blankMode ? vLong : vShort;
    strb.fFlag   = (line >= 10'd265) || (line <= 10'd2);
    strb.hFlag   = (pos < POS_W'(4));
    strb.isCode  = strb.hFlag || (pos >= SAV_AT && pos < ACT_AT);
    strb.codeIdx = strb.hFlag ? pos[1:0] : 2'(pos - SAV_AT);
    strb.isLuma  = pos[0];
    strb.takePix = (pos >= ACT_AT) && !strb.vFlag;
    strb.hdLvl   = (pos < SAV_AT);
  end

  p_pos_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == POS_LAST) |=> (pos == '0));
  p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == POS_LAST && line == LINE_LAST) |=> (line == LINE_W'(1)));
endmodule

// File: rtl/bt656_fmt_data.sv
module bt656_fmt_data
  import bt656_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clampEn,
  input  logic [7:0] pixIn,
  input  fmtStrobe_t strb,
  output logic [7:0] byteOut,
  output logic       hdOut,
  output logic       vdOut,
  output logic       fieldOut
);
  logic [7:0] nextByte, pixVal;
  logic [7:0] xyWord;

  always_comb begin
    xyWord = {1'b1, strb.fFlag, strb.vFlag, strb.hFlag,
              strb.vFlag ^ strb.hFlag, strb.fFlag ^ strb.hFlag,
              strb.fFlag ^ strb.vFlag, strb.fFlag ^ strb.vFlag ^ strb.hFlag};
    pixVal = pixIn;
    if (strb.isLuma && clampEn && pixVal < BLACK_Y) pixVal = BLACK_Y;
    if (pixVal == 8'h00) pixVal = 8'h01;
    if (pixVal == 8'hFF) pixVal = 8'hFE;
    if (strb.isCode) begin
      case (strb.codeIdx)
        2'd0:    nextByte = 8'hFF;
        2'd3:    nextByte = xyWord;
        default: nextByte = 8'h00;
      endcase
    end else if (strb.takePix) begin
      nextByte = pixVal;
    end else begin
      nextByte = strb.isLuma ? BLACK_Y : ZERO_C;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byteOut  <= BLACK_Y;
      hdOut    <= 1'b0;
      vdOut    <= 1'b0;
      fieldOut <= 1'b0;
    end else begin
      byteOut  <= nextByte;
      hdOut    <= strb.hdLvl;
      vdOut    <= strb.vFlag;
      fieldOut <= strb.fFlag;
    end
  end

  p_no_code_in_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.takePix) |-> (byteOut != 8'h00 && byteOut != 8'hFF));
  p_clamp_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strb.takePix && strb.isLuma) && clampEn) |-> (byteOut >= BLACK_Y));
  p_xy_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.isCode && strb.codeIdx == 2'd3) |-> byteOut[7]);
  p_hd_not_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.takePix) |-> !hdOut);
endmodule

// File: rtl/bt656_ntsc_formatter.sv
module bt656_ntsc_formatter
  import bt656_fmt_pkg::*;
#(
  parameter int BLANK_BYTES  = 268,
  parameter int ACTIVE_BYTES = 1440
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blankMode,
  input  logic       clampEn,
  input  logic [7:0] pixIn,
  output logic       sampleTake,
  output logic [7:0] byteOut,
  output logic       hdOut,
  output logic       vdOut,
  output logic       fieldOut
);
  fmtStrobe_t strb;

  bt656_fmt_ctrl #(.BLANK_BYTES(BLANK_BYTES), .ACTIVE_BYTES(ACTIVE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .blankMode(blankMode), .strb(strb));

  bt656_fmt_data u_data (
    .clk(clk), .rst_n(rst_n), .clampEn(clampEn), .pixIn(pixIn), .strb(strb),
    .byteOut(byteOut), .hdOut(hdOut), .vdOut(vdOut), .fieldOut(fieldOut));

  assign sampleTake = strb.takePix;
endmodule

// File: tb/bt656_ntsc_formatter_tb.sv
module bt656_ntsc_formatter_tb;
  localparam int BL = 8;
  localparam int AC = 16;
  localparam int LN = BL + AC + 8;
  localparam int FRAME = 525 * LN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blankMode = 1'b0;
  logic clampEn = 1'b0;
  logic [7:0] pixIn = 8'h00;
  logic sampleTake;
  logic [7:0] byteOut;
  logic hdOut, vdOut, fieldOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bt656_ntsc_formatter #(.BLANK_BYTES(BL), .ACTIVE_BYTES(AC)) u_dut (
    .clk(clk), .rst_n(rst_n), .blankMode(blankMode), .clampEn(clampEn),
    .pixIn(pixIn), .sampleTake(sampleTake), .byteOut(byteOut),
    .hdOut(hdOut), .vdOut(vdOut), .fieldOut(fieldOut));

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit refV(input int ln, input bit md);
    if (md) return (ln <= 18) || (ln >= 263 && ln <= 281) || ln == 525;
    return (ln <= 8) || (ln >= 263 && ln <= 271) || ln == 525;
  endfunction

  function automatic bit refF(input int ln);
    return (ln >= 265) || (ln <= 2);
  endfunction

  function automatic logic [7:0] pattern(input int k);
    case (k % 7)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h05;
      3: return 8'h10;
      default: return 8'((k * 37) & 255);
    endcase
  endfunction

  // pending expectation for the next output sample
  logic [7:0] expByte;
  bit expHd, expVd, expFd, expValid;
  string expTag, vdTag;

  task automatic run_config(input bit md, input bit cl, input int ncyc);
    int ln = 1;
    int ps = 0;
    rst_n = 1'b0;
    blankMode = md;
    clampEn = cl;
    expValid = 0;
    vdTag = md ? "R5" : "R4";
    repeat (3) @(negedge clk);
    check("R11 reset byte", byteOut, 8'h10);
    check("R11 reset hd/vd/field", {hdOut, vdOut, fieldOut}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      bit v, f, luma;
      int dpos;
      logic [7:0] d;
      if (expValid) begin
        check(expTag, byteOut, expByte);
        check("R10 hdOut", hdOut, expHd);
        check({vdTag, " vdOut"}, vdOut, expVd);
        check("R3 fieldOut", fieldOut, expFd);
      end
      pixIn = pattern(k);
      v = refV(ln, md);
      f = refF(ln);
      luma = ps[0];
      expHd = (ps < BL + 4);
      expVd = v;
      expFd = f;
      if (ps < 4 || (ps >= BL + 4 && ps < BL + 8)) begin
        bit h = (ps < 4);
        int idx = h ? ps : ps - BL - 4;
        expTag = (idx == 3) ? "R2 XY code" : "R1 code preamble";
        if (idx == 0) expByte = 8'hFF;
        else if (idx == 3) expByte = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        else expByte = 8'h00;
        check("R7 sampleTake in code", sampleTake, 0);
      end else if (ps < BL + 4 || v) begin
        expTag = "R6 blanking fill";
        expByte = luma ? 8'h10 : 8'h80;
        check("R7 sampleTake in blanking", sampleTake, 0);
      end else begin
        dpos = ps - (BL + 8);
        d = pixIn;
        expTag = (dpos % 2 == 1) ? "R7 luma data" : "R7 chroma data";
        if (luma && cl && d < 8'h10) begin d = 8'h10; expTag = "R8 clamp"; end
        if (d == 8'h00) begin d = 8'h01; expTag = "R9 limit low"; end
        if (d == 8'hFF) begin d = 8'hFE; expTag = "R9 limit high"; end
        expByte = d;
        check("R7 sampleTake in active", sampleTake, 1);
      end
      if (k == 0) check("R11 first byte is line-1 EAV", expByte, 8'hFF);
      expValid = 1;
      ps++;
      if (ps == LN) begin
        ps = 0;
        ln = (ln == 525) ? 1 : ln + 1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    run_config(1'b0, 1'b1, FRAME + 3 * LN);  // R4, R8 clamp on
    run_config(1'b1, 1'b0, FRAME + 3 * LN);  // R5, R8 clamp off
    run_config(1'b1, 1'b1, 40 * LN);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule